// File: doc/BRIEF.md
# Selectable Odd/Even Clock Divider with Symmetric Output

This block takes a fast source clock and divides it by three, four, five or six, chosen by a two-bit select code. The divided clock is symmetric for every ratio: for the odd ratios the output edges fall alternately on rising and falling source edges, so high and low times are each exactly half the divided period.

The divided clock feeds two output lanes. Each lane has its own enable and is modelled as a value plus a drive flag, where a cleared drive flag stands for a high-impedance pin. A synchronous active-high master reset holds the divider and forces every lane value low. When the reset clears, division restarts at once. A new select code is taken up only when the current divided period finishes.

Top module: `divsel_clkgen`

## Requirements
- R1: The select code `div_sel` sets the divide ratio N as 00 → 3, 01 → 4, 10 → 5, 11 → 6. Once settled, one period of the divided output lasts N source periods.
- R2: For every ratio, odd ones included, the divided output stays high for exactly N source half-periods and low for exactly N source half-periods.
- R3: While `mr` is high, every `q_val` bit is 0 and the divider is held, with its phase cleared on each clock edge. When `mr` goes low, division resumes with the ratio selected at that time.
- R4: When `oe[i]` is 1, `q_drv[i]` is 1 and `q_val[i]` carries the divided clock. When `oe[i]` is 0, `q_drv[i]` is 0 and `q_val[i]` is held at 0. Bit 0 controls lane 0 and bit 1 controls lane 1.
- R5: Lanes that are both enabled carry the identical divided clock, edge for edge.
- R6: The ratio in use changes only on the source edge that ends a divided period. Around a change, no output high or low interval is shorter than two source half-periods, and later periods use the new ratio.
- R7: After `mr` is released, the internal phase goes high on the first source rising edge. The first output rising edge therefore comes within one divided period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast source clock to be divided |
| mr | input | 1 | Master reset, synchronous, active high |
| div_sel | input | 2 | Divide ratio select code |
| oe | input | 2 | Per-lane output enable, bit i for lane i |
| q_val | output | 2 | Per-lane output value |
| q_drv | output | 2 | Per-lane drive flag, 0 means high impedance |

## Verification
The assertions check on every cycle that:
- the counter stays below the active ratio;
- the active ratio moves only at a counter wrap;
- reset clears the phase;
- the phase rises on the first edge after release;
- the output is never high unless the phase is.

Only the bench's scenarios can show the measured high and low times in half-periods for each ratio, the interval lengths across a ratio switch, the high-impedance behaviour for every enable combination, and the agreement between the two lanes. These are measured at the ports under directed and seeded random settings.

// File: rtl/divsel_pkg.sv
package divsel_pkg;

    localparam int SEL_W      = 2;
    localparam int BASE_RATIO = 3;
    localparam int NUM_RATIOS = 1 << SEL_W;
    localparam int MAX_RATIO  = BASE_RATIO + NUM_RATIOS - 1;
    localparam int CNT_W      = $clog2(MAX_RATIO);
    localparam int RAT_W      = $clog2(MAX_RATIO + 1);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [RAT_W-1:0] ratio_t;

    typedef enum logic {
        MODE_EVEN = 1'b0,
        MODE_ODD  = 1'b1
    } parity_e;

    typedef struct packed {
        cnt_t   count;
        ratio_t ratio;
    } div_state_t;

    // Ratio grows by one per select step starting at BASE_RATIO.
    function automatic ratio_t sel_to_ratio(sel_t s);
        return ratio_t'(BASE_RATIO) + ratio_t'(s);
    endfunction

    // Rising-edge cycles the phase stays high: ceil(N/2).
    function automatic cnt_t high_count(ratio_t r);
        return cnt_t'((int'(r) + 1) / 2);
    endfunction

    function automatic parity_e parity_of(ratio_t r);
        return r[0] ? MODE_ODD : MODE_EVEN;
    endfunction

    function automatic cnt_t last_count(ratio_t r);
        return cnt_t'(int'(r) - 1);
    endfunction

endpackage

// File: rtl/divsel_counter.sv
module divsel_counter
    import divsel_pkg::*;
(
    input  logic    clk,
    input  logic    mr,
    input  sel_t    sel,
    output logic    phase,
    output parity_e parity
);

    div_state_t st_q, st_d;
    logic       ph_q, ph_d;
    logic       wrap;

    assign wrap = (st_q.count == last_count(st_q.ratio));

    always_comb begin
        st_d = st_q;
        if (wrap) begin
            st_d.count = '0;
            st_d.ratio = sel_to_ratio(sel);
        end else begin
            st_d.count = st_q.count + cnt_t'(1);
        end
        ph_d = (st_d.count < high_count(st_d.ratio));
    end

    // Reset parks the counter on its last state so the first edge after
    // release wraps and opens a fresh high phase.
    always_ff @(posedge clk) begin
        if (mr) begin
            st_q.ratio <= sel_to_ratio(sel);
            st_q.count <= last_count(sel_to_ratio(sel));
            ph_q       <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
        end
    end

    assign phase  = ph_q;
    assign parity = parity_of(st_q.ratio);

    a_r1_count_below_ratio: assert property (@(posedge clk) disable iff (mr)
        int'(st_q.count) < int'(st_q.ratio));

    a_r6_ratio_moves_at_wrap: assert property (@(posedge clk) disable iff (mr)
        (!$past(mr) && (st_q.ratio != $past(st_q.ratio)))
        |-> (int'($past(st_q.count)) == int'($past(st_q.ratio)) - 1));

    a_r3_phase_low_after_reset: assert property (@(posedge clk)
        $past(mr) |-> !ph_q);

    a_r7_first_phase_after_release: assert property (@(posedge clk) disable iff (mr)
        $fell(mr) |=> ph_q);

endmodule

// File: rtl/divsel_halfshift.sv
module divsel_halfshift
    import divsel_pkg::*;
(
    input  logic    clk,
    input  logic    mr,
    input  logic    phase,
    input  parity_e parity,
    output logic    clk_div
);

    logic ph_neg_q;
    logic shaped;

    // Copy of the phase delayed by half a source period.
    always_ff @(negedge clk) begin
        if (mr) ph_neg_q <= 1'b0;
        else    ph_neg_q <= phase;
    end

    // Odd ratios: AND trims the ceil(N/2) phase by one half-period.
    always_comb begin
        unique case (parity)
            MODE_ODD:  shaped = phase & ph_neg_q;
            default:   shaped = phase;
        endcase
    end

    assign clk_div = shaped & ~mr;

    a_r2_out_needs_phase: assert property (@(posedge clk) disable iff (mr)
        clk_div |-> phase);

endmodule

// File: rtl/divsel_lane.sv
module divsel_lane (
    input  logic src,
    input  logic en,
    output logic val,
    output logic drv
);

    assign drv = en;
    assign val = en & src;

endmodule

// File: rtl/divsel_clkgen.sv
module divsel_clkgen
    import divsel_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                 clk_fast,
    input  logic                 mr,
    input  logic [SEL_W-1:0]     div_sel,
    input  logic [NUM_LANES-1:0] oe,
    output logic [NUM_LANES-1:0] q_val,
    output logic [NUM_LANES-1:0] q_drv
);

    logic    phase;
    parity_e parity;
    logic    clk_div;

    divsel_counter u_count (
        .clk    (clk_fast),
        .mr     (mr),
        .sel    (div_sel),
        .phase  (phase),
        .parity (parity)
    );

    divsel_halfshift u_shape (
        .clk     (clk_fast),
        .mr      (mr),
        .phase   (phase),
        .parity  (parity),
        .clk_div (clk_div)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        divsel_lane u_lane (
            .src (clk_div),
            .en  (oe[i]),
            .val (q_val[i]),
            .drv (q_drv[i])
        );
    end

endmodule

// File: tb/sim_divsel_clkgen.sv
module sim_divsel_clkgen;

    logic       clk = 1'b0;
    logic       mr = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic [1:0] oe = 2'b11;
    logic [1:0] q_val;
    logic [1:0] q_drv;

    int checks = 0;
    int fails  = 0;
    int runlen [16];
    bit lanes_ok;

    always #5 clk = ~clk;

    divsel_clkgen u0 (
        .clk_fast (clk),
        .mr       (mr),
        .div_sel  (div_sel),
        .oe       (oe),
        .q_val    (q_val),
        .q_drv    (q_drv)
    );

    function automatic int ratio_of(logic [1:0] s);
        return 3 + int'(s);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Step to the middle of the next source half-period.
    task automatic half_step;
        @(clk);
        #2;
    endtask

    task automatic at_negedge;
        @(negedge clk);
        #1;
    endtask

    // Record lengths (in half-periods) of consecutive lane-0 intervals.
    task automatic capture(input int runs);
        logic prev;
        int   len;
        int   g;
        lanes_ok = 1'b1;
        half_step;
        prev = q_val[0];
        g = 0;
        while (q_val[0] == prev && g < 40) begin
            half_step;
            g++;
        end
        for (int k = 0; k < runs; k++) begin
            prev = q_val[0];
            len = 0;
            while (q_val[0] == prev && len < 40) begin
                if (q_val[1] !== q_val[0]) lanes_ok = 1'b0;
                len++;
                half_step;
            end
            runlen[k] = len;
        end
    endtask

    task automatic measure_ratio(input logic [1:0] s);
        int n;
        n = ratio_of(s);
        at_negedge;
        div_sel = s;
        repeat (24) half_step;
        capture(4);
        for (int k = 0; k < 4; k++)
            chk(runlen[k] == n, "R2", $sformatf("interval sel=%0d", s), runlen[k], n);
        chk(runlen[0] + runlen[1] == 2 * n, "R1", $sformatf("period sel=%0d", s),
            runlen[0] + runlen[1], 2 * n);
        if (oe == 2'b11)
            chk(lanes_ok, "R5", "lanes identical", int'(lanes_ok), 1);
    endtask

    task automatic switch_check(input logic [1:0] from_s, input logic [1:0] to_s);
        int n;
        int shortest;
        at_negedge;
        div_sel = from_s;
        repeat (24) half_step;
        at_negedge;
        div_sel = to_s;
        capture(10);
        n = ratio_of(to_s);
        shortest = 99;
        for (int k = 0; k < 10; k++)
            if (runlen[k] < shortest) shortest = runlen[k];
        chk(shortest >= 2, "R6", $sformatf("shortest interval %0d->%0d", from_s, to_s),
            shortest, 2);
        chk(runlen[8] == n && runlen[9] == n, "R6", "settled interval after switch",
            runlen[8], n);
    endtask

    initial begin : watchdog
        #1_500_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        int cnt;
        bit saw_hi;
        bit saw_lo;
        bit quiet;
        logic [1:0] rs;

        // Reset state
        repeat (4) @(posedge clk);
        half_step;
        chk(q_val == 2'b00, "R3", "outputs low in reset", int'(q_val), 0);
        chk(q_drv == 2'b11, "R4", "drive follows enables in reset", int'(q_drv), 3);

        // First edge after release, ratio 3
        at_negedge;
        mr = 1'b0;
        cnt = 0;
        do begin
            half_step;
            cnt++;
        end while (!q_val[0] && cnt < 40);
        chk(cnt <= 6, "R7", "half-periods to first rise", cnt, 6);

        // Every ratio, directed
        for (int s = 0; s < 4; s++) measure_ratio(2'(s));

        // Reset in mid-run
        at_negedge;
        mr = 1'b1;
        quiet = 1'b1;
        repeat (10) begin
            half_step;
            if (q_val != 2'b00) quiet = 1'b0;
        end
        chk(quiet, "R3", "outputs held low while mr high", int'(quiet), 1);
        at_negedge;
        mr = 1'b0;
        measure_ratio(2'b10);

        // Ratio switches
        switch_check(2'b01, 2'b00);
        switch_check(2'b00, 2'b11);
        switch_check(2'b11, 2'b10);
        switch_check(2'b10, 2'b01);

        // Enable combinations
        at_negedge;
        div_sel = 2'b01;
        for (int e = 0; e < 4; e++) begin
            at_negedge;
            oe = 2'(e);
            half_step;
            chk(q_drv == 2'(e), "R4", "drive flags", int'(q_drv), e);
            for (int l = 0; l < 2; l++) begin
                saw_hi = 1'b0;
                saw_lo = 1'b0;
                for (int t = 0; t < 16; t++) begin
                    if (t > 0) half_step;
                    if (q_val[l]) saw_hi = 1'b1;
                    else          saw_lo = 1'b1;
                end
                if (e[l])
                    chk(saw_hi && saw_lo, "R4", $sformatf("lane %0d toggles", l),
                        int'(saw_hi && saw_lo), 1);
                else
                    chk(!saw_hi, "R4", $sformatf("lane %0d quiet in hi-z", l),
                        int'(saw_hi), 0);
            end
        end

        // Seeded random settings
        void'($urandom(32'd2718));
        for (int r = 0; r < 8; r++) begin
            rs = 2'($urandom % 4);
            at_negedge;
            oe = {1'($urandom % 2), 1'b1};
            measure_ratio(rs);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule